// File: doc/BRIEF.md
# Single-Transfer DMA Engine

This block is a one-shot DMA controller that copies a run of 32-bit words between a private 4096-byte staging buffer and system memory. Software programs a source address, a destination address and a byte count, then writes a command word that starts the transfer. The staging buffer sits in the device's own address space at 0x40000. The command word also picks the direction and asks for an interrupt when the transfer ends. Addresses outside that window refer to system memory, which is reached through a simple word master port that holds each request until it is acknowledged.

Register decode belongs to a front end. It presents an already-decoded offset, an access size and write data, and it reads back through a combinational read port. A start delay, set by a parameter in clock cycles, separates the accepted command from the first memory beat. The local address range is then checked. A range that fails the check ends the transfer with no data moved and leaves a sticky error flag. On normal completion the run bit drops, and a one-cycle interrupt pulse goes to the front end's interrupt status, at bit 8 there.

Top module: `dmaEngine`

## Requirements
- R1: After reset the source, destination, count and command registers all read zero, `memReq` is low and `irqSet` is low.
- R2: Offsets 0x80, 0x88, 0x90 and 0x98 select source, destination, count and command. An 8-byte write (`regSize`=8) stores all 64 bits. A 4-byte write (`regSize`=4) stores the low 32 bits zero-extended. A write of any other size leaves the register unchanged.
- R3: A command write whose data has bit 0 clear is ignored. The command register keeps its value and no memory beat starts.
- R4: While the run bit is set, writes to any of the four registers are ignored.
- R5: Command bit 0 is run, bit 1 is direction and bit 2 enables the completion interrupt. Bit 3 is a read-only error flag, cleared by the next accepted command. Direction 0 copies `cnt` bytes from system memory at the source address into the buffer at the destination address.
- R6: Direction 1 copies `cnt` bytes from the buffer at the source address to system memory at the destination address.
- R7: The local range must meet all of these: a nonzero count, a count and a local address that are multiples of 4, and [addr, addr+cnt) inside [0x40000, 0x41000). On a violation no beat is issued, run clears, bit 3 sets and no interrupt pulse is sent.
- R8: The system-side address is ANDed with 0x0FFFFFFF, the mask for SYS_ADDR_BITS=28, so `memAddr[31:28]` is always zero.
- R9: No memory beat starts within START_DELAY cycles of the accepting command write.
- R10: On completion run clears. `irqSet` is high for exactly one cycle, the first cycle in which run reads 0, and only if bit 2 was set.
- R11: Each beat moves one 32-bit word at ascending addresses (step 4), starting at the programmed address. `memReq`, `memWe`, `memAddr` and `memWdata` hold steady until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Decoded register offset |
| regSize | input | 4 | Access size in bytes |
| regWdata | input | 64 | Register write data |
| regRdata | output | 64 | Read data for `regAddr` (combinational) |
| memReq | output | 1 | System memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Masked system byte address |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request accepted; read data valid |
| memRdata | input | 32 | Read data |
| irqSet | output | 1 | One-cycle completion interrupt pulse |

## Verification
The assertions assume the memory side never raises `memAck` without a pending `memReq`. They also assume that the front end drives `regSize` only with byte counts and holds `regAddr` steady around the clock edge. The bench's memory model raises `memAck` for one cycle only in response to a request that has not yet been acknowledged. Its register tasks change inputs only on falling edges. Every programmed transfer keeps system addresses inside the model's 256-word window once the mask is applied.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam logic [7:0] OFF_SRC = 8'h80;
  localparam logic [7:0] OFF_DST = 8'h88;
  localparam logic [7:0] OFF_CNT = 8'h90;
  localparam logic [7:0] OFF_CMD = 8'h98;

  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IEN = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPtrs;
    logic stepPtrs;
    logic bufRe;
    logic bufWe;
    logic finish;
    logic abort;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic run;
    logic toSys;
    logic rangeOk;
    logic lastBeat;
  } dpStatus_t;
endpackage

// File: rtl/dmaLocalBuf.sv
module dmaLocalBuf #(
  parameter int WORDS = 1024,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaPkg::*;
#(
  parameter int          REG_W         = 64,
  parameter int          ADDR_W        = 32,
  parameter int          SYS_ADDR_BITS = 28,
  parameter logic [31:0] LCL_BASE      = 32'h0004_0000,
  parameter logic [31:0] LCL_BYTES     = 32'd4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regAddr,
  input  logic [3:0]       regSize,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  ctlStrobe_t       ctl,
  output dpStatus_t        stat,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata,
  output logic             irqSet
);
  localparam int BUF_WORDS = int'(LCL_BYTES) / 4;
  localparam int BUF_AW    = $clog2(BUF_WORDS);
  localparam int BEAT_W    = BUF_AW + 1;
  localparam logic [REG_W:0] LCL_LO = {{(REG_W+1-32){1'b0}}, LCL_BASE};
  localparam logic [REG_W:0] LCL_HI = {{(REG_W+1-32){1'b0}}, LCL_BASE + LCL_BYTES};
  localparam logic [ADDR_W-1:0] SYS_MASK =
    {{(ADDR_W-SYS_ADDR_BITS){1'b0}}, {SYS_ADDR_BITS{1'b1}}};

  logic [REG_W-1:0] srcReg, dstReg, cntReg;
  logic runBit, dirBit, ienBit, errBit;

  logic             sizeOk, wrOk;
  logic [REG_W-1:0] wrVal;

  assign sizeOk = (regSize == 4'd4) || (regSize == 4'd8);
  assign wrVal  = (regSize == 4'd8) ? regWdata : {{(REG_W-32){1'b0}}, regWdata[31:0]};
  assign wrOk   = regWe && sizeOk && !runBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg <= '0;
      dstReg <= '0;
      cntReg <= '0;
      runBit <= 1'b0;
      dirBit <= 1'b0;
      ienBit <= 1'b0;
      errBit <= 1'b0;
      irqSet <= 1'b0;
    end else begin
      if (wrOk && regAddr == OFF_SRC) srcReg <= wrVal;
      if (wrOk && regAddr == OFF_DST) dstReg <= wrVal;
      if (wrOk && regAddr == OFF_CNT) cntReg <= wrVal;
      if (wrOk && regAddr == OFF_CMD && wrVal[CMD_RUN]) begin
        runBit <= 1'b1;
        dirBit <= wrVal[CMD_DIR];
        ienBit <= wrVal[CMD_IEN];
        errBit <= 1'b0;
      end
      if (ctl.finish) runBit <= 1'b0;
      if (ctl.abort) begin
        runBit <= 1'b0;
        errBit <= 1'b1;
      end
      irqSet <= ctl.finish && ienBit;
    end
  end

  always_comb begin
    case (regAddr)
      OFF_SRC: regRdata = srcReg;
      OFF_DST: regRdata = dstReg;
      OFF_CNT: regRdata = cntReg;
      OFF_CMD: regRdata = {{(REG_W-4){1'b0}}, errBit, ienBit, dirBit, runBit};
      default: regRdata = '0;
    endcase
  end

  // local range check
  logic [REG_W-1:0] lclAddr;
  logic [REG_W:0]   lclEnd;
  assign lclAddr = dirBit ? srcReg : dstReg;
  assign lclEnd  = {1'b0, lclAddr} + {1'b0, cntReg};

  assign stat.rangeOk = (cntReg != '0) && (cntReg[1:0] == 2'b00) &&
                        (lclAddr[1:0] == 2'b00) &&
                        ({1'b0, lclAddr} >= LCL_LO) && (lclEnd <= LCL_HI);
  assign stat.run   = runBit;
  assign stat.toSys = dirBit;

  // transfer pointers; base is aligned to the window size
  logic [BUF_AW-1:0] lclPtr;
  logic [ADDR_W-1:0] sysPtr;
  logic [BEAT_W-1:0] beatsLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lclPtr    <= '0;
      sysPtr    <= '0;
      beatsLeft <= '0;
    end else if (ctl.loadPtrs) begin
      lclPtr    <= lclAddr[BUF_AW+1:2];
      sysPtr    <= (dirBit ? dstReg[ADDR_W-1:0] : srcReg[ADDR_W-1:0]) & SYS_MASK;
      beatsLeft <= cntReg[BUF_AW+2:2];
    end else if (ctl.stepPtrs) begin
      lclPtr    <= lclPtr + 1'b1;
      sysPtr    <= (sysPtr + ADDR_W'(4)) & SYS_MASK;
      beatsLeft <= beatsLeft - 1'b1;
    end
  end

  assign stat.lastBeat = (beatsLeft == BEAT_W'(1));
  assign memAddr = sysPtr;

  dmaLocalBuf #(.WORDS(BUF_WORDS)) uBuf (
    .clk  (clk),
    .we   (ctl.bufWe),
    .re   (ctl.bufRe),
    .addr (lclPtr),
    .wdata(memRdata),
    .rdata(memWdata)
  );

  assert_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && regWe) |=> ($stable(srcReg) && $stable(dstReg) && $stable(cntReg)));

  assert_irq_after_run_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqSet |-> (!runBit && $past(runBit)));

  assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abort |=> (!irqSet && errBit));

  assert_bufwe_dir_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.bufWe |-> !dirBit);
endmodule

// File: rtl/dmaControl.sv
module dmaControl
  import dmaPkg::*;
#(
  parameter int START_DELAY = 8,
  localparam int DLY_W = $clog2(START_DELAY + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  stat,
  input  logic       memAck,
  output ctlStrobe_t ctl,
  output logic       memReq,
  output logic       memWe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_CHECK, ST_RDBUF, ST_MEMWR, ST_MEMRD, ST_FINISH
  } state_t;

  state_t state, nextState;
  logic [DLY_W-1:0] delayCnt;

  always_comb begin
    ctl       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE:  if (stat.run) nextState = ST_WAIT;
      ST_WAIT:  if (delayCnt == DLY_W'(START_DELAY - 1)) nextState = ST_CHECK;
      ST_CHECK: begin
        if (!stat.rangeOk) begin
          ctl.abort = 1'b1;
          nextState = ST_IDLE;
        end else begin
          ctl.loadPtrs = 1'b1;
          nextState = stat.toSys ? ST_RDBUF : ST_MEMRD;
        end
      end
      ST_RDBUF: begin
        ctl.bufRe = 1'b1;
        nextState = ST_MEMWR;
      end
      ST_MEMWR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          ctl.stepPtrs = 1'b1;
          nextState = stat.lastBeat ? ST_FINISH : ST_RDBUF;
        end
      end
      ST_MEMRD: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.bufWe    = 1'b1;
          ctl.stepPtrs = 1'b1;
          nextState = stat.lastBeat ? ST_FINISH : ST_MEMRD;
        end
      end
      ST_FINISH: begin
        ctl.finish = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      delayCnt <= '0;
    end else begin
      state    <= nextState;
      delayCnt <= (state == ST_WAIT) ? delayCnt + 1'b1 : '0;
    end
  end

  // cycles since run rose, saturating; used only by the delay check
  logic [DLY_W-1:0] sinceRun;
  always_ff @(posedge clk) begin
    if (!rstN || !stat.run) sinceRun <= '0;
    else if (sinceRun != DLY_W'(START_DELAY)) sinceRun <= sinceRun + 1'b1;
  end

  assert_delay_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (sinceRun == DLY_W'(START_DELAY)));

  assert_req_under_run_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> stat.run);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));
endmodule

// File: rtl/dmaEngine.sv
module dmaEngine
  import dmaPkg::*;
#(
  parameter int          REG_W         = 64,
  parameter int          ADDR_W        = 32,
  parameter int          SYS_ADDR_BITS = 28,
  parameter logic [31:0] LCL_BASE      = 32'h0004_0000,
  parameter logic [31:0] LCL_BYTES     = 32'd4096,
  parameter int          START_DELAY   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [7:0]        regAddr,
  input  logic [3:0]        regSize,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              irqSet
);
  ctlStrobe_t ctl;
  dpStatus_t  stat;

  dmaControl #(.START_DELAY(START_DELAY)) uCtl (
    .clk   (clk),
    .rstN  (rstN),
    .stat  (stat),
    .memAck(memAck),
    .ctl   (ctl),
    .memReq(memReq),
    .memWe (memWe)
  );

  dmaDatapath #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .SYS_ADDR_BITS(SYS_ADDR_BITS),
    .LCL_BASE(LCL_BASE), .LCL_BYTES(LCL_BYTES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regAddr (regAddr),
    .regSize (regSize),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .ctl     (ctl),
    .stat    (stat),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memRdata(memRdata),
    .irqSet  (irqSet)
  );

  assert_beat_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWdata)));
endmodule

// File: tb/tb_dmaEngine.sv
module tb_dmaEngine;
  localparam int DLY = 8;
  localparam logic [7:0] A_SRC = 8'h80, A_DST = 8'h88, A_CNT = 8'h90, A_CMD = 8'h98;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [7:0] regAddr = 8'h0;
  logic [3:0] regSize = 4'd8;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic memReq, memWe, irqSet;
  logic [31:0] memAddr, memWdata;
  logic memAck;
  logic [31:0] memRdata;

  always #5 clk = ~clk;

  dmaEngine #(.START_DELAY(DLY)) dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regSize(regSize),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .irqSet(irqSet)
  );

  // system memory model: 256 words, one-cycle acknowledge
  logic [31:0] sysMem [256];
  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) sysMem[memAddr[9:2]] <= memWdata;
      else memRdata <= sysMem[memAddr[9:2]];
    end else memAck <= 1'b0;
  end

  // monitor
  int beats = 0, irqCount = 0, maskErr = 0, orderErr = 0;
  logic clrMon = 1'b0;
  logic [31:0] firstAddr = '0, lastAddr = '0;
  always @(posedge clk) begin
    if (clrMon) begin
      beats <= 0;
    end else if (memReq && memAck) begin
      if (beats == 0) firstAddr <= memAddr;
      else if (memAddr != lastAddr + 32'd4) orderErr <= orderErr + 1;
      lastAddr <= memAddr;
      beats <= beats + 1;
      if (memAddr[31:28] != 4'h0) maskErr <= maskErr + 1;
    end
    if (irqSet) irqCount <= irqCount + 1;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regSize = sz; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic clearMon();
    @(negedge clk); clrMon = 1'b1;
    @(negedge clk); clrMon = 1'b0;
  endtask

  // wait for run to drop; report irqSet in that first idle cycle
  task automatic waitDone(output logic irqAtEnd, output logic irqNext);
    irqAtEnd = 1'b0; irqNext = 1'b0;
    @(negedge clk);
    regAddr = A_CMD;
    for (int i = 0; i < 5000; i++) begin
      #1;
      if (!regRdata[0]) begin
        irqAtEnd = irqSet;
        @(negedge clk); #1 irqNext = irqSet;
        return;
      end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [7:0]  addr;
    logic [3:0]  size;
    logic [63:0] data;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{A_SRC, 4'd8, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 4'd2},
    '{A_SRC, 4'd4, 64'hFFFF_FFFF_1111_2222, 64'h0000_0000_1111_2222, 4'd2},
    '{A_DST, 4'd8, 64'h0000_0000_0004_0010, 64'h0000_0000_0004_0010, 4'd2},
    '{A_DST, 4'd2, 64'h0000_0000_0000_5555, 64'h0000_0000_0004_0010, 4'd2},
    '{A_CNT, 4'd4, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0010, 4'd2},
    '{A_CMD, 4'd8, 64'h0000_0000_0000_0006, 64'h0000_0000_0000_0000, 4'd3},
    '{A_CNT, 4'd1, 64'h0000_0000_0000_0099, 64'h0000_0000_0000_0010, 4'd2}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] rd;
    logic irqA, irqB;
    int irqBefore, seen;

    for (int i = 0; i < 256; i++) sysMem[i] = 32'h0;
    for (int i = 0; i < 4; i++) sysMem[64+i] = 32'hA5A5_0000 + 32'(i * 17);
    for (int i = 0; i < 2; i++) sysMem[192+i] = 32'h3C3C_1000 + 32'(i);

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(A_SRC, rd); chk(rd == 0, "R1 src after reset", rd, 0);
    regRead(A_DST, rd); chk(rd == 0, "R1 dst after reset", rd, 0);
    regRead(A_CNT, rd); chk(rd == 0, "R1 cnt after reset", rd, 0);
    regRead(A_CMD, rd); chk(rd == 0, "R1 cmd after reset", rd, 0);
    chk(!memReq && !irqSet, "R1 memReq/irqSet low", {62'b0, memReq, irqSet}, 0);

    // vector walk: R2 sizes and offsets, R3 command without run
    foreach (VECS[k]) begin
      regWrite(VECS[k].addr, VECS[k].size, VECS[k].data);
      regRead(VECS[k].addr, rd);
      chk(rd == VECS[k].exp, $sformatf("R%0d vector %0d", VECS[k].req, k), rd, VECS[k].exp);
    end
    clearMon();
    repeat (DLY + 6) @(negedge clk);
    chk(beats == 0, "R3 no beat after cmd without run", 64'(beats), 0);

    // T1: system -> buffer with interrupt (R5, R9, R10, R11)
    regWrite(A_SRC, 4'd8, 64'h100);
    regWrite(A_DST, 4'd8, 64'h40010);
    regWrite(A_CNT, 4'd8, 64'd16);
    clearMon();
    irqBefore = irqCount;
    regWrite(A_CMD, 4'd8, 64'h5);
    seen = 0;
    for (int i = 0; i < DLY; i++) begin
      if (memReq) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R9 no beat inside start delay", 64'(seen), 0);
    regWrite(A_SRC, 4'd8, 64'hDEAD);
    regRead(A_SRC, rd); chk(rd == 64'h100, "R4 src locked while running", rd, 64'h100);
    waitDone(irqA, irqB);
    chk(irqA == 1'b1, "R10 irq pulse in first idle cycle", 64'(irqA), 1);
    chk(irqB == 1'b0, "R10 irq pulse one cycle", 64'(irqB), 0);
    chk(irqCount == irqBefore + 1, "R10 one pulse", 64'(irqCount), 64'(irqBefore + 1));
    chk(beats == 4 && firstAddr == 32'h100, "R11 four beats from src", {32'(beats), firstAddr}, {32'd4, 32'h100});

    // T2: buffer -> system, no interrupt (R6, R5)
    regWrite(A_SRC, 4'd8, 64'h40010);
    regWrite(A_DST, 4'd8, 64'h200);
    clearMon();
    irqBefore = irqCount;
    regWrite(A_CMD, 4'd8, 64'h3);
    waitDone(irqA, irqB);
    chk(irqCount == irqBefore, "R10 no irq when disabled", 64'(irqCount), 64'(irqBefore));
    for (int i = 0; i < 4; i++)
      chk(sysMem[128+i] == 32'hA5A5_0000 + 32'(i * 17), "R6 R5 round trip word",
          64'(sysMem[128+i]), 64'(32'hA5A5_0000 + 32'(i * 17)));
    chk(firstAddr == 32'h200 && orderErr == 0, "R11 ascending from dst",
        {firstAddr, 32'(orderErr)}, {32'h200, 32'd0});

    // T3: address mask (R8)
    regWrite(A_SRC, 4'd8, 64'hF000_0300);
    regWrite(A_DST, 4'd8, 64'h40100);
    regWrite(A_CNT, 4'd8, 64'd8);
    clearMon();
    regWrite(A_CMD, 4'd8, 64'h1);
    waitDone(irqA, irqB);
    chk(firstAddr == 32'h300, "R8 masked source", 64'(firstAddr), 64'h300);
    regWrite(A_SRC, 4'd8, 64'h40100);
    regWrite(A_DST, 4'd8, 64'h0000_0001_1000_0380);
    clearMon();
    regWrite(A_CMD, 4'd8, 64'h3);
    waitDone(irqA, irqB);
    chk(firstAddr == 32'h380, "R8 masked destination", 64'(firstAddr), 64'h380);
    chk(sysMem[224] == 32'h3C3C_1000 && sysMem[225] == 32'h3C3C_1001, "R8 data through mask",
        {sysMem[224], sysMem[225]}, {32'h3C3C_1000, 32'h3C3C_1001});
    chk(maskErr == 0, "R8 upper address bits zero", 64'(maskErr), 0);

    // T4: range violations (R7) and err clear (R5)
    regWrite(A_SRC, 4'd8, 64'h100);
    regWrite(A_DST, 4'd8, 64'h40FF8);
    regWrite(A_CNT, 4'd8, 64'd16);
    clearMon();
    irqBefore = irqCount;
    regWrite(A_CMD, 4'd8, 64'h5);
    waitDone(irqA, irqB);
    regRead(A_CMD, rd);
    chk(rd == 64'hC, "R7 overrun sets err, clears run", rd, 64'hC);
    chk(beats == 0 && irqCount == irqBefore, "R7 no beat, no irq on overrun",
        {32'(beats), 32'(irqCount)}, {32'd0, 32'(irqBefore)});
    regWrite(A_DST, 4'd8, 64'h40000);
    regWrite(A_CNT, 4'd8, 64'd0);
    regWrite(A_CMD, 4'd8, 64'h1);
    waitDone(irqA, irqB);
    regRead(A_CMD, rd); chk(rd == 64'h8, "R7 zero count rejected", rd, 64'h8);
    regWrite(A_DST, 4'd8, 64'h40002);
    regWrite(A_CNT, 4'd8, 64'd4);
    regWrite(A_CMD, 4'd8, 64'h1);
    waitDone(irqA, irqB);
    regRead(A_CMD, rd); chk(rd == 64'h8, "R7 misaligned local address rejected", rd, 64'h8);
    regWrite(A_DST, 4'd8, 64'h3FFFC);
    regWrite(A_CMD, 4'd8, 64'h1);
    waitDone(irqA, irqB);
    regRead(A_CMD, rd); chk(rd == 64'h8, "R7 below window rejected", rd, 64'h8);
    regWrite(A_DST, 4'd8, 64'h40FF0);
    regWrite(A_CNT, 4'd8, 64'd16);
    clearMon();
    regWrite(A_CMD, 4'd8, 64'h1);
    waitDone(irqA, irqB);
    regRead(A_CMD, rd); chk(rd == 64'h0, "R5 err cleared by next command; R7 end boundary ok", rd, 64'h0);
    chk(beats == 4, "R7 boundary transfer moves four words", 64'(beats), 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule